// File: doc/BRIEF.md
# Operand Bypass and Load Hazard Unit

This block resolves data hazards in a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back). It looks at the source register numbers of the instruction about to execute. It compares them with the destination numbers and write flags of the two older instructions still in flight. From that comparison it picks, for each ALU operand, whether the value comes from the register file, from the result held after execute, or from the result held after memory access.

The same unit also spots a load whose result is needed by the very next instruction. For one cycle it then freezes the program counter and the fetch/decode register, and it tells the decode stage to send an all-zero control word (a bubble) into execute. The block is purely combinational. The datapath, register file and memories sit outside it and use its outputs directly in the same cycle.

Top module: `hazard_resolver`

## Requirements
- R1: `fwd_a` is 2'b10 (take the execute/memory-stage result) when `exm_wr` is 1, `exm_rd` is nonzero and `exm_rd` equals `ex_rs`.
- R2: `fwd_a` is 2'b01 (take the memory/write-back-stage result) when `mwb_wr` is 1, `mwb_rd` is nonzero, `mwb_rd` equals `ex_rs`, and R1 does not apply.
- R3: `fwd_b` follows the rules of R1 and R2 with `ex_rt` in place of `ex_rs`, independently of `fwd_a`.
- R4: A select is 2'b00 (register file value) when no enabled, nonzero destination matches that source; a matching destination whose write flag is 0 has no effect.
- R5: When both older stages match the same source, the select is 2'b10, because the younger producer wins.
- R6: A destination of register 0 never causes forwarding, even with its write flag set.
- R7: When `ex_mem_rd` is 1 and `ex_rt` equals `dec_rs` or `dec_rt`, then `pc_we` is 0, `ifid_we` is 0 and `bubble` is 1.
- R8: Otherwise `pc_we` is 1, `ifid_we` is 1 and `bubble` is 0. This includes a load with no match and a register match with no load.
- R9: One cycle after a load-use stall, when the load sits in memory/write-back and the bubble sits in execute/memory, the dependent operand select is 2'b01 and no further stall is requested.
- R10: For an ALU producer of r2 followed by a consumer of r2 as first source and then a consumer of r2 as second source, the first consumer gets `fwd_a`=2'b10 and the second gets `fwd_b`=2'b01.
- R11: A producer three instructions ahead is already in the register file, which writes before it reads within a cycle, so its consumer gets select 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | REG_AW | First source register of the instruction in execute |
| ex_rt | input | REG_AW | Second source register of the instruction in execute; also the load destination |
| ex_mem_rd | input | 1 | Instruction in execute reads data memory (load) |
| exm_wr | input | 1 | Execute/memory-stage instruction writes a register |
| exm_rd | input | REG_AW | Execute/memory-stage destination register |
| mwb_wr | input | 1 | Memory/write-back-stage instruction writes a register |
| mwb_rd | input | REG_AW | Memory/write-back-stage destination register |
| dec_rs | input | REG_AW | First source register of the instruction in decode |
| dec_rt | input | REG_AW | Second source register of the instruction in decode |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 write-back stage, 10 memory stage |
| fwd_b | output | 2 | Operand B select, same encoding |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble | output | 1 | Zero the control bits entering execute |

## Verification
A wrong comparison or a wrong priority inside the unit shows up at once: in the same cycle, an operand select names the wrong source. Downstream, that becomes a stale or a too-new operand in the ALU result one stage later. A broken load detector appears as a missing or a spurious hold on `pc_we`, `ifid_we` and `bubble` in the very cycle the load is in execute. If nothing catches it there, a wrong value is written back two cycles later. Since no state is kept, every fault can be seen in the cycle whose inputs trigger it.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_MEMWB   = 2'b01,
    SEL_EXMEM   = 2'b10
  } opnd_sel_e;
endpackage

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              exm_wr,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic              mwb_wr,
  input  logic [REG_AW-1:0] mwb_rd,
  output opnd_sel_e         sel
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic hit_exm;
  logic hit_mwb;

  assign hit_exm = exm_wr && (exm_rd != ZERO_REG) && (exm_rd == src);
  assign hit_mwb = mwb_wr && (mwb_rd != ZERO_REG) && (mwb_rd == src);

  // the younger producer takes precedence
  always_comb begin
    if (hit_exm)      sel = SEL_EXMEM;
    else if (hit_mwb) sel = SEL_MEMWB;
    else              sel = SEL_REGFILE;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_AW = 5
) (
  input  logic              ld_pend,
  input  logic [REG_AW-1:0] ld_rd,
  input  logic [REG_AW-1:0] dec_rs,
  input  logic [REG_AW-1:0] dec_rt,
  output logic              hold
);
  assign hold = ld_pend && ((ld_rd == dec_rs) || (ld_rd == dec_rt));
endmodule

// File: rtl/hazard_resolver.sv
module hazard_resolver
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_rs,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic              ex_mem_rd,
  input  logic              exm_wr,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic              mwb_wr,
  input  logic [REG_AW-1:0] mwb_rd,
  input  logic [REG_AW-1:0] dec_rs,
  input  logic [REG_AW-1:0] dec_rt,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              bubble
);
  localparam int NUM_SRC = 2;

  logic [REG_AW-1:0] src_num [NUM_SRC];
  opnd_sel_e         src_sel [NUM_SRC];
  logic              hold;

  assign src_num[0] = ex_rs;
  assign src_num[1] = ex_rt;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hz_opnd_sel #(.REG_AW(REG_AW)) u_sel (
      .src    (src_num[g]),
      .exm_wr (exm_wr),
      .exm_rd (exm_rd),
      .mwb_wr (mwb_wr),
      .mwb_rd (mwb_rd),
      .sel    (src_sel[g])
    );
  end

  hz_load_use #(.REG_AW(REG_AW)) u_ldu (
    .ld_pend (ex_mem_rd),
    .ld_rd   (ex_rt),
    .dec_rs  (dec_rs),
    .dec_rt  (dec_rt),
    .hold    (hold)
  );

  assign fwd_a   = src_sel[0];
  assign fwd_b   = src_sel[1];
  assign pc_we   = ~hold;
  assign ifid_we = ~hold;
  assign bubble  = hold;
endmodule

// File: rtl/hazard_resolver_chk.sv
module hazard_resolver_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] ex_rs,
  input logic [REG_AW-1:0] ex_rt,
  input logic              ex_mem_rd,
  input logic              exm_wr,
  input logic [REG_AW-1:0] exm_rd,
  input logic              mwb_wr,
  input logic [REG_AW-1:0] mwb_rd,
  input logic [REG_AW-1:0] dec_rs,
  input logic [REG_AW-1:0] dec_rt,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              pc_we,
  input logic              ifid_we,
  input logic              bubble
);
  always_comb begin
    if (!$isunknown({fwd_a, fwd_b, exm_rd, mwb_rd, ex_rs, ex_rt})) begin
      // R1, R5: memory-stage select implies an enabled nonzero match
      a_r1_exm_source_valid: assert (fwd_a != 2'b10 || (exm_wr && exm_rd != '0 && exm_rd == ex_rs));
      // R2: write-back select implies a match and no memory-stage match
      a_r2_mwb_source_valid: assert (fwd_a != 2'b01 ||
        (mwb_wr && mwb_rd != '0 && mwb_rd == ex_rs && !(exm_wr && exm_rd == ex_rs)));
      // R3: operand B select uses the same sources
      a_r3_b_source_valid: assert (fwd_b == 2'b00 ||
        (fwd_b == 2'b10 && exm_rd == ex_rt) || (fwd_b == 2'b01 && mwb_rd == ex_rt));
      // R6: register 0 never bypassed
      a_r6_zero_never_fwd: assert (!(ex_rs == '0 && fwd_a != 2'b00) && !(ex_rt == '0 && fwd_b != 2'b00));
      // R4: the encoding 2'b11 is never produced
      a_r4_legal_codes: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    end
    if (!$isunknown({pc_we, ifid_we, bubble, ex_mem_rd})) begin
      // R7, R8: the three stall controls agree
      a_r7_stall_consistent: assert (pc_we == ifid_we && bubble == !pc_we);
      // R8: no stall without a load in execute
      a_r8_no_load_no_stall: assert (ex_mem_rd || !bubble);
    end
  end
endmodule

bind hazard_resolver hazard_resolver_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/hazard_resolver_bench.sv
module hazard_resolver_bench;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ex_rs = '0, ex_rt = '0, exm_rd = '0, mwb_rd = '0, dec_rs = '0, dec_rt = '0;
  logic          ex_mem_rd = 1'b0, exm_wr = 1'b0, mwb_wr = 1'b0;
  logic [1:0]    fwd_a, fwd_b;
  logic          pc_we, ifid_we, bubble;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  hazard_resolver #(.REG_AW(AW)) u_hazard_resolver (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_mem_rd(ex_mem_rd),
    .exm_wr(exm_wr), .exm_rd(exm_rd), .mwb_wr(mwb_wr), .mwb_rd(mwb_rd),
    .dec_rs(dec_rs), .dec_rt(dec_rt),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one pipeline snapshot away from the clock edge, then settle
  task automatic drive(input logic [AW-1:0] rs, rt, input logic exw, input logic [AW-1:0] exd,
                       input logic mww, input logic [AW-1:0] mwd, input logic ld,
                       input logic [AW-1:0] drs, drt);
    @(negedge clk);
    ex_rs = rs; ex_rt = rt; exm_wr = exw; exm_rd = exd;
    mwb_wr = mww; mwb_rd = mwd; ex_mem_rd = ld; dec_rs = drs; dec_rt = drt;
    #1;
  endtask

  task automatic check_run(string tag);
    check(tag, {5'b0, pc_we, ifid_we, bubble}, 8'h06);
  endtask

  task automatic check_hold(string tag);
    check(tag, {5'b0, pc_we, ifid_we, bubble}, 8'h01);
  endtask

  task automatic t_idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R4 idle fwd_a", fwd_a, 0);
    check("R4 idle fwd_b", fwd_b, 0);
    check_run("R8 idle stall ctl");
  endtask

  task automatic t_exm();
    drive(7, 9, 1, 7, 0, 0, 0, 1, 1);
    check("R1 fwd_a from exm", fwd_a, 2'b10);
    check("R3 fwd_b untouched", fwd_b, 0);
  endtask

  task automatic t_mwb();
    drive(11, 4, 0, 0, 1, 11, 0, 1, 1);
    check("R2 fwd_a from mwb", fwd_a, 2'b01);
    drive(3, 11, 1, 20, 1, 11, 0, 1, 1);
    check("R3 fwd_b from mwb", fwd_b, 2'b01);
    check("R4 fwd_a no match", fwd_a, 0);
    drive(6, 6, 1, 6, 0, 0, 0, 1, 1);
    check("R3 fwd_b from exm", fwd_b, 2'b10);
    check("R1 fwd_a same reg", fwd_a, 2'b10);
  endtask

  task automatic t_prio();
    drive(8, 8, 1, 8, 1, 8, 0, 1, 1);
    check("R5 fwd_a both match", fwd_a, 2'b10);
    check("R5 fwd_b both match", fwd_b, 2'b10);
    drive(8, 8, 0, 8, 1, 8, 0, 1, 1);
    check("R4 exm flag clear", fwd_a, 2'b01);
    drive(8, 8, 0, 8, 0, 8, 0, 1, 1);
    check("R4 both flags clear", fwd_b, 0);
  endtask

  task automatic t_zero();
    drive(0, 0, 1, 0, 1, 0, 0, 1, 1);
    check("R6 zero fwd_a", fwd_a, 0);
    check("R6 zero fwd_b", fwd_b, 0);
    drive(0, 0, 1, 0, 1, 0, 0, 1, 1);
    check("R6 zero fwd_b again", fwd_b, 0);
  endtask

  task automatic t_load_use();
    drive(1, 2, 0, 0, 0, 0, 1, 2, 5);
    check_hold("R7 load matches dec_rs");
    drive(1, 2, 0, 0, 0, 0, 1, 5, 2);
    check_hold("R7 load matches dec_rt");
    drive(1, 2, 0, 0, 0, 0, 1, 5, 6);
    check_run("R8 load no match");
    drive(1, 2, 0, 0, 0, 0, 0, 2, 2);
    check_run("R8 match without load");
  endtask

  task automatic t_after_stall();
    // lw r2 in ID/EX, and r4,r2,r5 in IF/ID
    drive(0, 2, 0, 0, 0, 0, 1, 2, 5);
    check_hold("R9 stall cycle");
    // next: bubble in EX/MEM, lw in MEM/WB, and in ID/EX
    drive(2, 5, 0, 0, 1, 2, 0, 7, 8);
    check("R9 fwd_a after stall", fwd_a, 2'b01);
    check_run("R9 no second stall");
  endtask

  task automatic t_sequence();
    // and r12,r2,r5 in EX; sub r2 in EX/MEM
    drive(2, 5, 1, 2, 0, 0, 0, 6, 2);
    check("R10 and rs from exm", fwd_a, 2'b10);
    // or r13,r6,r2 in EX; and r12 in EX/MEM; sub r2 in MEM/WB
    drive(6, 2, 1, 12, 1, 2, 0, 2, 2);
    check("R10 or rt from mwb", fwd_b, 2'b01);
    check("R10 or rs regfile", fwd_a, 0);
  endtask

  task automatic t_three_ahead();
    // add r14,r2,r2 in EX; sub r2 already written this cycle
    drive(2, 2, 1, 13, 1, 12, 0, 2, 2);
    check("R11 rs from regfile", fwd_a, 0);
    check("R11 rt from regfile", fwd_b, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_exm();
    t_mwb();
    t_prio();
    t_zero();
    t_load_use();
    t_after_stall();
    t_sequence();
    t_three_ahead();
    finish_up();
  end
endmodule